// File: doc/BRIEF.md
# Banked UART Register Access Decoder

This block is the host-side register file of an enhanced UART. A narrow bus with a 3-bit address, 8-bit data and separate read and write strobes reaches more registers than its eight offsets can hold directly. The current line control value and two bits of the additional control register choose which hidden bank each offset reaches. The banks are the 16-bit baud divisor, the enhanced feature register, an indexed control bank and a set of extra status registers.

The indexed bank works through two offsets. The host stores an index in the pointer register at offset 7, then accesses the data window at offset 5. All configuration registers are brought out as output ports for the shifter, FIFOs and baud generator, which lie outside this block. The FIFO fill levels come in as inputs and can be read back through the status bank. Read data is registered: the byte is captured on the read strobe and held until the next read strobe.

Top module: `uart_bank_regs`

## Requirements
- R1: After asynchronous reset, every register output is 0x00 and `rdata` is 0x00.
- R2: While `line_ctl[7]` is 1 and `line_ctl` is not 0xBF, offset 0 reads and writes the divisor low byte and offset 1 reads and writes the divisor high byte. While `line_ctl[7]` is 0, offset 1 is the interrupt enable register and offset 0 reads 0x00 and ignores writes.
- R3: While `line_ctl` holds 0xBF, offset 2 reads and writes the enhanced feature register and offset 3 reads and writes the line control register. Every other offset reads 0x00 and ignores writes. Any other line control value leaves this bank.
- R4: A write to offset 5 stores the data into the indexed register selected by the pointer at offset 7. The indices are 0x00 additional control, 0x01 clock prescaler, 0x02 times-clock, 0x04 transmit trigger, 0x05 receive trigger and 0x0C soft reset. Writes to any other index have no effect.
- R5: A read of offset 5 returns the indexed register only while `addl_ctl[6]` is 1. Otherwise it returns 0x00. The soft-reset index and unmapped indices read 0x00.
- R6: While `addl_ctl[7]` is 1 (and neither bank of R2 or R3 applies), reads of offsets 1, 3 and 4 return the additional status, `rx_level` and `tx_level`. A write to offset 1 goes to the additional status register.
- R7: Only bits 1:0 of the additional status register take write data. Bits 7:2 always read 0.
- R8: Writing 0x00 to indexed register 0x0C clears every register to 0x00 on that edge. Writing a nonzero value there has no effect.
- R9: `modem_ctl[7]` (prescaler enable) changes on an offset 4 write only while `feat_ctl[4]` is 1. Bits 6:0 are always written.
- R10: `rdata` is loaded only on a read strobe and keeps its value while `rd_en` is low, even when `rx_level` or `tx_level` change.
- R11: Read data appears on `rdata` after the clock edge that samples `rd_en`. Register writes take effect on the edge that samples `wr_en`.
- R12: Offset 2 outside the 0xBF bank reads and writes the FIFO control register. Offset 7 reads and writes the index pointer. Offset 6 reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 3 | Register offset |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rx_level | input | 8 | Receive FIFO fill level |
| tx_level | input | 8 | Transmit FIFO fill level |
| rdata | output | 8 | Registered read data |
| baud_div | output | 16 | Baud divisor |
| int_en | output | 8 | Interrupt enable register |
| fifo_ctl | output | 8 | FIFO control register |
| line_ctl | output | 8 | Line control register |
| modem_ctl | output | 8 | Modem control register |
| feat_ctl | output | 8 | Enhanced feature register |
| addl_ctl | output | 8 | Additional control register |
| clk_pre | output | 8 | Clock prescaler |
| times_clk | output | 8 | Times-clock register |
| tx_trig | output | 8 | Transmit trigger level |
| rx_trig | output | 8 | Receive trigger level |
| addl_stat | output | 8 | Additional status (bits 1:0 held) |

## Verification
A write is visible on the register outputs one edge after the strobe. The bench drives each strobe at a falling edge and checks the outputs at the next falling edge, after exactly one rising edge has passed. Read data also takes one edge, so each read task raises `rd_en` for one cycle and compares `rdata` half a cycle after the capturing edge. The hold check changes the FIFO level inputs over several further cycles with `rd_en` low and confirms that `rdata` keeps the captured byte.

// File: rtl/uart_bank_pkg.sv
package uart_bank_pkg;
    localparam int DW = 8;
    localparam int AW = 3;

    localparam logic [DW-1:0] LCR_BANK_KEY = 8'hBF;
    localparam int LCR_DIV_BIT = 7;
    localparam int ACR_IRD_BIT = 6;
    localparam int ACR_XST_BIT = 7;
    localparam int EFR_ENH_BIT = 4;
    localparam int MCR_PRE_BIT = 7;
    localparam int ASR_W       = 2;

    localparam logic [DW-1:0] IX_ACR = 8'h00;
    localparam logic [DW-1:0] IX_CPR = 8'h01;
    localparam logic [DW-1:0] IX_TCR = 8'h02;
    localparam logic [DW-1:0] IX_TTL = 8'h04;
    localparam logic [DW-1:0] IX_RTL = 8'h05;
    localparam logic [DW-1:0] IX_CSR = 8'h0C;

    typedef enum logic [3:0] {
        T_NONE, T_DLL, T_DLM, T_IER, T_FCR, T_LCR, T_MCR,
        T_SPR, T_ICR, T_EFR, T_ASR, T_RFL, T_TFL
    } tgt_e;

    typedef struct packed {
        logic [DW-1:0] dll;
        logic [DW-1:0] dlm;
        logic [DW-1:0] ier;
        logic [DW-1:0] fcr;
        logic [DW-1:0] lcr;
        logic [DW-1:0] mcr;
        logic [DW-1:0] spr;
        logic [DW-1:0] efr;
        logic [ASR_W-1:0] asr;
    } core_t;

    typedef struct packed {
        logic [DW-1:0] acr;
        logic [DW-1:0] cpr;
        logic [DW-1:0] tcr;
        logic [DW-1:0] ttl;
        logic [DW-1:0] rtl;
    } icr_t;
endpackage

// File: rtl/uart_bank_decode.sv
module uart_bank_decode
    import uart_bank_pkg::*;
(
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] lcr,
    input  logic [DW-1:0] acr,
    output tgt_e          wr_tgt,
    output tgt_e          rd_tgt
);
    logic key_bank, div_bank, xst_bank, ird_en;

    always_comb begin
        key_bank = (lcr == LCR_BANK_KEY);
        div_bank = lcr[LCR_DIV_BIT];
        xst_bank = acr[ACR_XST_BIT];
        ird_en   = acr[ACR_IRD_BIT];
        wr_tgt   = T_NONE;
        rd_tgt   = T_NONE;
        if (key_bank) begin
            unique case (addr)
                3'd2:    begin wr_tgt = T_EFR; rd_tgt = T_EFR; end
                3'd3:    begin wr_tgt = T_LCR; rd_tgt = T_LCR; end
                default: begin wr_tgt = T_NONE; rd_tgt = T_NONE; end
            endcase
        end else begin
            unique case (addr)
                3'd0: begin
                    wr_tgt = div_bank ? T_DLL : T_NONE;
                    rd_tgt = div_bank ? T_DLL : T_NONE;
                end
                3'd1: begin
                    wr_tgt = div_bank ? T_DLM : (xst_bank ? T_ASR : T_IER);
                    rd_tgt = div_bank ? T_DLM : (xst_bank ? T_ASR : T_IER);
                end
                3'd2: begin wr_tgt = T_FCR; rd_tgt = T_FCR; end
                3'd3: begin wr_tgt = T_LCR; rd_tgt = xst_bank ? T_RFL : T_LCR; end
                3'd4: begin wr_tgt = T_MCR; rd_tgt = xst_bank ? T_TFL : T_MCR; end
                3'd5: begin wr_tgt = T_ICR; rd_tgt = ird_en ? T_ICR : T_NONE; end
                3'd6: begin wr_tgt = T_NONE; rd_tgt = T_NONE; end
                default: begin wr_tgt = T_SPR; rd_tgt = T_SPR; end
            endcase
        end
    end
endmodule

// File: rtl/uart_bank_icr.sv
module uart_bank_icr
    import uart_bank_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [DW-1:0] idx,
    input  logic [DW-1:0] wdata,
    output logic          soft_clr,
    output icr_t          regs,
    output logic [DW-1:0] rd_val
);
    icr_t regs_d, regs_q;

    always_comb begin
        regs_d   = regs_q;
        soft_clr = wr && (idx == IX_CSR) && (wdata == '0);
        if (wr) begin
            unique case (idx)
                IX_ACR:  regs_d.acr = wdata;
                IX_CPR:  regs_d.cpr = wdata;
                IX_TCR:  regs_d.tcr = wdata;
                IX_TTL:  regs_d.ttl = wdata;
                IX_RTL:  regs_d.rtl = wdata;
                default: regs_d = regs_q;
            endcase
        end
        if (soft_clr) regs_d = '0;
    end

    always_comb begin
        unique case (idx)
            IX_ACR:  rd_val = regs_q.acr;
            IX_CPR:  rd_val = regs_q.cpr;
            IX_TCR:  rd_val = regs_q.tcr;
            IX_TTL:  rd_val = regs_q.ttl;
            IX_RTL:  rd_val = regs_q.rtl;
            default: rd_val = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign regs = regs_q;

    p_soft_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        soft_clr |=> (regs_q == '0));
endmodule

// File: rtl/uart_bank_rdmux.sv
module uart_bank_rdmux
    import uart_bank_pkg::*;
(
    input  tgt_e          rd_tgt,
    input  core_t         core,
    input  logic [DW-1:0] icr_val,
    input  logic [DW-1:0] rx_level,
    input  logic [DW-1:0] tx_level,
    output logic [DW-1:0] val
);
    always_comb begin
        unique case (rd_tgt)
            T_DLL:   val = core.dll;
            T_DLM:   val = core.dlm;
            T_IER:   val = core.ier;
            T_FCR:   val = core.fcr;
            T_LCR:   val = core.lcr;
            T_MCR:   val = core.mcr;
            T_SPR:   val = core.spr;
            T_EFR:   val = core.efr;
            T_ICR:   val = icr_val;
            T_ASR:   val = {{(DW-ASR_W){1'b0}}, core.asr};
            T_RFL:   val = rx_level;
            T_TFL:   val = tx_level;
            default: val = '0;
        endcase
    end
endmodule

// File: rtl/uart_bank_regs.sv
module uart_bank_regs
    import uart_bank_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   addr,
    input  logic [DW-1:0]   wdata,
    input  logic            wr_en,
    input  logic            rd_en,
    input  logic [DW-1:0]   rx_level,
    input  logic [DW-1:0]   tx_level,
    output logic [DW-1:0]   rdata,
    output logic [2*DW-1:0] baud_div,
    output logic [DW-1:0]   int_en,
    output logic [DW-1:0]   fifo_ctl,
    output logic [DW-1:0]   line_ctl,
    output logic [DW-1:0]   modem_ctl,
    output logic [DW-1:0]   feat_ctl,
    output logic [DW-1:0]   addl_ctl,
    output logic [DW-1:0]   clk_pre,
    output logic [DW-1:0]   times_clk,
    output logic [DW-1:0]   tx_trig,
    output logic [DW-1:0]   rx_trig,
    output logic [DW-1:0]   addl_stat
);
    core_t         core_d, core_q;
    logic [DW-1:0] rdata_d, rdata_q;
    tgt_e          wr_tgt, rd_tgt;
    icr_t          icr_regs;
    logic [DW-1:0] icr_val, rd_val;
    logic          soft_clr;

    uart_bank_decode u_dec (
        .addr   (addr),
        .lcr    (core_q.lcr),
        .acr    (icr_regs.acr),
        .wr_tgt (wr_tgt),
        .rd_tgt (rd_tgt)
    );

    uart_bank_icr u_icr (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (wr_en && (wr_tgt == T_ICR)),
        .idx      (core_q.spr),
        .wdata    (wdata),
        .soft_clr (soft_clr),
        .regs     (icr_regs),
        .rd_val   (icr_val)
    );

    uart_bank_rdmux u_mux (
        .rd_tgt   (rd_tgt),
        .core     (core_q),
        .icr_val  (icr_val),
        .rx_level (rx_level),
        .tx_level (tx_level),
        .val      (rd_val)
    );

    always_comb begin
        core_d  = core_q;
        rdata_d = rdata_q;
        if (wr_en) begin
            unique case (wr_tgt)
                T_DLL: core_d.dll = wdata;
                T_DLM: core_d.dlm = wdata;
                T_IER: core_d.ier = wdata;
                T_FCR: core_d.fcr = wdata;
                T_LCR: core_d.lcr = wdata;
                T_SPR: core_d.spr = wdata;
                T_EFR: core_d.efr = wdata;
                T_ASR: core_d.asr = wdata[ASR_W-1:0];
                T_MCR: begin
                    core_d.mcr = wdata;
                    if (!core_q.efr[EFR_ENH_BIT])
                        core_d.mcr[MCR_PRE_BIT] = core_q.mcr[MCR_PRE_BIT];
                end
                default: core_d = core_q;
            endcase
        end
        if (soft_clr) core_d = '0;
        if (rd_en)    rdata_d = rd_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_q  <= '0;
            rdata_q <= '0;
        end else begin
            core_q  <= core_d;
            rdata_q <= rdata_d;
        end
    end

    assign rdata     = rdata_q;
    assign baud_div  = {core_q.dlm, core_q.dll};
    assign int_en    = core_q.ier;
    assign fifo_ctl  = core_q.fcr;
    assign line_ctl  = core_q.lcr;
    assign modem_ctl = core_q.mcr;
    assign feat_ctl  = core_q.efr;
    assign addl_stat = {{(DW-ASR_W){1'b0}}, core_q.asr};
    assign addl_ctl  = icr_regs.acr;
    assign clk_pre   = icr_regs.cpr;
    assign times_clk = icr_regs.tcr;
    assign tx_trig   = icr_regs.ttl;
    assign rx_trig   = icr_regs.rtl;

    p_div_low_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 3'd0 && line_ctl[LCR_DIV_BIT] && line_ctl != LCR_BANK_KEY)
        |=> baud_div[DW-1:0] == $past(wdata));

    p_key_bank_locks_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 3'd5 && line_ctl == LCR_BANK_KEY) |=> $stable(addl_ctl));

    p_window_read_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 3'd5 && line_ctl != LCR_BANK_KEY && !addl_ctl[ACR_IRD_BIT])
        |=> rdata == '0);

    p_stat_write_bits_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_tgt == T_ASR) |=> addl_stat == {{(DW-ASR_W){1'b0}}, $past(wdata[ASR_W-1:0])});

    p_prescaler_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 3'd4 && line_ctl != LCR_BANK_KEY && !feat_ctl[EFR_ENH_BIT])
        |=> modem_ctl[MCR_PRE_BIT] == $past(modem_ctl[MCR_PRE_BIT]));

    p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));
endmodule

// File: tb/uart_bank_regs_bench.sv
module uart_bank_regs_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  rx_level = '0;
    logic [7:0]  tx_level = '0;
    logic [7:0]  rdata;
    logic [15:0] baud_div;
    logic [7:0]  int_en, fifo_ctl, line_ctl, modem_ctl, feat_ctl, addl_ctl;
    logic [7:0]  clk_pre, times_clk, tx_trig, rx_trig, addl_stat;
    int n_run = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    uart_bank_regs u_uart_bank_regs (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
        .rd_en(rd_en), .rx_level(rx_level), .tx_level(tx_level), .rdata(rdata),
        .baud_div(baud_div), .int_en(int_en), .fifo_ctl(fifo_ctl),
        .line_ctl(line_ctl), .modem_ctl(modem_ctl), .feat_ctl(feat_ctl),
        .addl_ctl(addl_ctl), .clk_pre(clk_pre), .times_clk(times_clk),
        .tx_trig(tx_trig), .rx_trig(rx_trig), .addl_stat(addl_stat)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        check(tag, {8'h0, rdata}, {8'h0, exp});
    endtask

    task automatic t_reset;
        check("R1 line_ctl", {8'h0, line_ctl}, 16'h0);
        check("R1 baud_div", baud_div, 16'h0);
        check("R1 addl_ctl", {8'h0, addl_ctl}, 16'h0);
        check("R1 rdata", {8'h0, rdata}, 16'h0);
        for (int a = 0; a < 8; a++) bus_rd(a[2:0], 8'h00, "R1 read after reset");
    endtask

    task automatic t_divisor;
        bus_wr(3, 8'h83);
        bus_wr(0, 8'h34);
        bus_wr(1, 8'h12);
        check("R2 divisor value", baud_div, 16'h1234);
        check("R2 ier untouched", {8'h0, int_en}, 16'h0);
        bus_rd(0, 8'h34, "R2 read low byte");
        bus_rd(1, 8'h12, "R2 read high byte");
        bus_wr(3, 8'h03);
        bus_wr(1, 8'h05);
        check("R2 normal offset1 is ier", {8'h0, int_en}, 16'h05);
        check("R2 divisor kept", baud_div, 16'h1234);
        bus_rd(1, 8'h05, "R2 read ier");
        bus_rd(0, 8'h00, "R2 offset0 normal reads zero");
    endtask

    task automatic t_enhanced;
        bus_wr(3, 8'hBF);
        bus_wr(2, 8'h10);
        check("R3 efr written", {8'h0, feat_ctl}, 16'h10);
        check("R3 fcr untouched", {8'h0, fifo_ctl}, 16'h0);
        bus_rd(2, 8'h10, "R3 read efr");
        bus_wr(5, 8'h77);
        bus_wr(7, 8'h55);
        bus_wr(1, 8'h09);
        check("R3 window write ignored", {8'h0, addl_ctl}, 16'h0);
        check("R3 ier write ignored", {8'h0, int_en}, 16'h05);
        bus_wr(3, 8'h03);
        bus_rd(7, 8'h00, "R3 pointer write ignored");
        bus_rd(2, 8'h00, "R3 left bank, offset2 is fcr");
        bus_wr(2, 8'h41);
        check("R12 fcr written", {8'h0, fifo_ctl}, 16'h41);
        bus_rd(2, 8'h41, "R12 read fcr");
        bus_rd(6, 8'h00, "R12 offset6 reads zero");
    endtask

    task automatic t_prescaler;
        bus_wr(4, 8'h88);
        check("R9 mcr with enhanced", {8'h0, modem_ctl}, 16'h88);
        bus_wr(3, 8'hBF);
        bus_wr(2, 8'h00);
        bus_wr(3, 8'h03);
        bus_wr(4, 8'h08);
        check("R9 prescaler held set", {8'h0, modem_ctl}, 16'h88);
        bus_wr(4, 8'h01);
        check("R9 low bits written", {8'h0, modem_ctl}, 16'h81);
    endtask

    task automatic t_indexed;
        bus_wr(7, 8'h01); bus_wr(5, 8'h08);
        bus_wr(7, 8'h02); bus_wr(5, 8'h04);
        bus_wr(7, 8'h04); bus_wr(5, 8'h7F);
        bus_wr(7, 8'h05); bus_wr(5, 8'h3F);
        check("R4 cpr", {8'h0, clk_pre}, 16'h08);
        check("R4 tcr", {8'h0, times_clk}, 16'h04);
        check("R4 ttl", {8'h0, tx_trig}, 16'h7F);
        check("R4 rtl", {8'h0, rx_trig}, 16'h3F);
        bus_rd(7, 8'h05, "R12 read pointer");
        bus_rd(5, 8'h00, "R5 window read gated off");
        bus_wr(7, 8'h00); bus_wr(5, 8'h40);
        check("R4 acr", {8'h0, addl_ctl}, 16'h40);
        bus_wr(7, 8'h01);
        bus_rd(5, 8'h08, "R5 window reads cpr");
        bus_wr(7, 8'h05);
        bus_rd(5, 8'h3F, "R5 window reads rtl");
        bus_wr(7, 8'h0C);
        bus_rd(5, 8'h00, "R5 soft-reset index reads zero");
        bus_wr(7, 8'h33); bus_wr(5, 8'hAA);
        bus_rd(5, 8'h00, "R5 unmapped index reads zero");
        check("R4 unmapped write no effect", {clk_pre, tx_trig}, 16'h087F);
        bus_wr(7, 8'h00); bus_wr(5, 8'h00);
        bus_wr(7, 8'h01);
        bus_rd(5, 8'h00, "R5 gate closed again");
    endtask

    task automatic t_status;
        rx_level = 8'h2A; tx_level = 8'h11;
        bus_wr(7, 8'h00); bus_wr(5, 8'h80);
        bus_rd(3, 8'h2A, "R6 rx level");
        bus_rd(4, 8'h11, "R6 tx level");
        bus_wr(1, 8'hFF);
        check("R7 status keeps two bits", {8'h0, addl_stat}, 16'h03);
        check("R6 ier not written", {8'h0, int_en}, 16'h05);
        bus_rd(1, 8'h03, "R7 read status");
        bus_wr(1, 8'hFC);
        bus_rd(1, 8'h00, "R7 upper bits ignored");
        bus_wr(1, 8'h02);
        rx_level = 8'h40;
        @(negedge clk);
        addr = 3; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        check("R11 data one edge after strobe", {8'h0, rdata}, 16'h40);
        rx_level = 8'h41; tx_level = 8'h99;
        repeat (3) @(negedge clk);
        check("R10 rdata held", {8'h0, rdata}, 16'h40);
        bus_wr(5, 8'h00);
        bus_rd(3, 8'h03, "R6 offset3 back to lcr");
        bus_rd(4, 8'h81, "R6 offset4 back to mcr");
    endtask

    task automatic t_soft_reset;
        bus_wr(7, 8'h0C); bus_wr(5, 8'h01);
        check("R8 nonzero no effect lcr", {8'h0, line_ctl}, 16'h03);
        check("R8 nonzero no effect cpr", {8'h0, clk_pre}, 16'h08);
        bus_wr(5, 8'h00);
        check("R8 lcr cleared", {8'h0, line_ctl}, 16'h0);
        check("R8 divisor cleared", baud_div, 16'h0);
        check("R8 mcr cleared", {8'h0, modem_ctl}, 16'h0);
        check("R8 status cleared", {8'h0, addl_stat}, 16'h0);
        check("R8 indexed cleared", {clk_pre, tx_trig}, 16'h0);
        check("R8 fcr ier cleared", {fifo_ctl, int_en}, 16'h0);
        bus_rd(7, 8'h00, "R8 pointer cleared");
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_fail++;
        n_run++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_divisor();
        t_enhanced();
        t_prescaler();
        t_indexed();
        t_status();
        t_soft_reset();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule